// File: doc/BRIEF.md
# Dual-Port Mailbox Memory with Doorbell Interrupts

This block is a two-port, 16-bit-wide word memory shared by two agents, called port A and port B. Either port can read or write any word at any time, both in the same clock domain. The two highest addresses double as mailboxes. A write by one port to the other port's mailbox rings a doorbell: an active-low interrupt output toward the receiving port. The receiving port acknowledges the doorbell by accessing its mailbox. Software that ignores the interrupts sees both top words as plain storage.

Port A's mailbox is address DEPTH-2, and port B's mailbox is address DEPTH-1. The depth is set as a power of two through `AW` (DEPTH = 2**AW). The rule for clearing port A's doorbell differs from the rule for port B's. Port A clears its doorbell with any access that has its output enable asserted. Port B can only clear its doorbell with a true read.

Top module: `mbox_dpram`

## Requirements
- R1: While `rst_n` is low, and after it is released, both `a_irq_n` and `b_irq_n` are 1 and both read-data outputs are 0.
- R2: A port writes `wdata` to `addr` on the rising edge where `cs_n`=0 and `we_n`=0. A port reads on the rising edge where `cs_n`=0 and `we_n`=1, and the word appears on its `rdata` after that edge. Data written by one port can be read back by the other port.
- R3: When `cs_n`=1, the port neither writes memory nor updates its `rdata`, whatever `we_n` and `addr` are.
- R4: A write by port B to address DEPTH-2 drives `a_irq_n` to 0 after that edge.
- R5: `a_irq_n` returns to 1 after an edge where port A has `cs_n`=0, `oe_n`=0 and `addr`=DEPTH-2, whether `we_n` is 0 or 1. With `oe_n`=1 the doorbell stays set.
- R6: A write by port A to address DEPTH-1 drives `b_irq_n` to 0 after that edge.
- R7: `b_irq_n` returns to 1 only after an edge where port B reads address DEPTH-1 with `cs_n`=0, `we_n`=1 and `oe_n`=0. A port B write to that address does not clear it, and neither does a read with `oe_n`=1.
- R8: If a doorbell is set and cleared on the same edge, it ends up set (0).
- R9: Both mailbox words hold full 16-bit values that either port can write and read like any other address.
- R10: If both ports write the same address on the same edge, port A's data is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both ports |
| rst_n | input | 1 | Active-low synchronous reset of the doorbells and read registers |
| a_cs_n | input | 1 | Port A select, active low |
| a_oe_n | input | 1 | Port A output enable, active low |
| a_we_n | input | 1 | Port A write strobe, active low |
| a_addr | input | AW | Port A word address |
| a_wdata | input | 16 | Port A write data |
| a_rdata | output | 16 | Port A registered read data |
| a_irq_n | output | 1 | Doorbell to port A, active low |
| b_cs_n | input | 1 | Port B select, active low |
| b_oe_n | input | 1 | Port B output enable, active low |
| b_we_n | input | 1 | Port B write strobe, active low |
| b_addr | input | AW | Port B word address |
| b_wdata | input | 16 | Port B write data |
| b_rdata | output | 16 | Port B registered read data |
| b_irq_n | output | 1 | Doorbell to port B, active low |

## Verification
The storage function is checked with a table of words written through port A and read back through port B. The table covers the lowest address, alternating bit patterns, all-ones and the word just below the mailboxes, so that addressing or data-lane faults show up as a wrong word. The doorbell tests then vary the control strobes on mailbox accesses. The cases are: a read with output enable off, a write with output enable on, port B writing its own mailbox, and a proper read. Together they separate port A's clear condition (output enable, read/write ignored) from port B's clear condition (a true read only). Simultaneous set-and-clear and same-address double writes confirm the two priority rules.

// File: rtl/mbox_dpram.sv
module mbox_dpram #(
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          a_cs_n,
  input  logic          a_oe_n,
  input  logic          a_we_n,
  input  logic [AW-1:0] a_addr,
  input  logic [15:0]   a_wdata,
  output logic [15:0]   a_rdata,
  output logic          a_irq_n,
  input  logic          b_cs_n,
  input  logic          b_oe_n,
  input  logic          b_we_n,
  input  logic [AW-1:0] b_addr,
  input  logic [15:0]   b_wdata,
  output logic [15:0]   b_rdata,
  output logic          b_irq_n
);
  localparam int DEPTH = 1 << AW;
  localparam logic [AW-1:0] MBX_A = AW'(DEPTH - 2);
  localparam logic [AW-1:0] MBX_B = AW'(DEPTH - 1);

  logic [15:0] mem [DEPTH];

  wire a_wr = !a_cs_n && !a_we_n;
  wire a_rd = !a_cs_n &&  a_we_n;
  wire b_wr = !b_cs_n && !b_we_n;
  wire b_rd = !b_cs_n &&  b_we_n;

  wire a_ring = b_wr && (b_addr == MBX_A);
  wire a_ack  = !a_cs_n && !a_oe_n && (a_addr == MBX_A);
  wire b_ring = a_wr && (a_addr == MBX_B);
  wire b_ack  = b_rd && !b_oe_n && (b_addr == MBX_B);

  always_ff @(posedge clk) begin
    if (b_wr) mem[b_addr] <= b_wdata;
    if (a_wr) mem[a_addr] <= a_wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      a_rdata <= '0;
      b_rdata <= '0;
    end else begin
      if (a_rd) a_rdata <= mem[a_addr];
      if (b_rd) b_rdata <= mem[b_addr];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      a_irq_n <= 1'b1;
      b_irq_n <= 1'b1;
    end else begin
      if (a_ring)     a_irq_n <= 1'b0;
      else if (a_ack) a_irq_n <= 1'b1;
      if (b_ring)     b_irq_n <= 1'b0;
      else if (b_ack) b_irq_n <= 1'b1;
    end
  end

  // R4
  a_ring_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!b_cs_n && !b_we_n && b_addr == MBX_A) |=> !a_irq_n);

  // R5
  a_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!a_cs_n && !a_oe_n && a_addr == MBX_A && !(!b_cs_n && !b_we_n && b_addr == MBX_A))
    |=> a_irq_n);

  // R6
  b_ring_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!a_cs_n && !a_we_n && a_addr == MBX_B) |=> !b_irq_n);

  // R7
  b_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!b_irq_n && !(!b_cs_n && b_we_n && !b_oe_n && b_addr == MBX_B)) |=> !b_irq_n);

  // R3
  a_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (a_cs_n && $past(rst_n)) |=> $stable(a_rdata));

  // R3
  b_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (b_cs_n && $past(rst_n)) |=> $stable(b_rdata));
endmodule

// File: tb/mbox_dpram_tb.sv
module mbox_dpram_tb;
  localparam int AW = 10;
  localparam int DEPTH = 1 << AW;
  localparam logic [AW-1:0] MBX_A = AW'(DEPTH - 2);
  localparam logic [AW-1:0] MBX_B = AW'(DEPTH - 1);
  localparam int NV = 6;
  localparam logic [AW+15:0] VEC [NV] = '{
    {10'd0,   16'hA5A5},
    {10'd1,   16'h5A5A},
    {10'd341, 16'hFFFF},
    {10'd682, 16'h0001},
    {10'd512, 16'h8000},
    {10'd1021,16'h3C3C}
  };

  logic clk = 0, rst_n = 0;
  logic a_cs_n = 1, a_oe_n = 1, a_we_n = 1;
  logic b_cs_n = 1, b_oe_n = 1, b_we_n = 1;
  logic [AW-1:0] a_addr = '0, b_addr = '0;
  logic [15:0] a_wdata = '0, b_wdata = '0;
  logic [15:0] a_rdata, b_rdata;
  logic a_irq_n, b_irq_n;
  int checks = 0, fails = 0;
  logic done = 0;
  logic [15:0] keep;

  always #2 clk = ~clk;

  mbox_dpram #(.AW(AW)) u_dut (
    .clk, .rst_n,
    .a_cs_n, .a_oe_n, .a_we_n, .a_addr, .a_wdata, .a_rdata, .a_irq_n,
    .b_cs_n, .b_oe_n, .b_we_n, .b_addr, .b_wdata, .b_rdata, .b_irq_n
  );

  task automatic tick(); @(negedge clk); endtask

  task automatic idle();
    a_cs_n = 1; a_oe_n = 1; a_we_n = 1;
    b_cs_n = 1; b_oe_n = 1; b_we_n = 1;
  endtask

  task automatic pa(input logic cs, oe, we, input logic [AW-1:0] ad, input logic [15:0] d);
    a_cs_n = cs; a_oe_n = oe; a_we_n = we; a_addr = ad; a_wdata = d;
  endtask

  task automatic pb(input logic cs, oe, we, input logic [AW-1:0] ad, input logic [15:0] d);
    b_cs_n = cs; b_oe_n = oe; b_we_n = we; b_addr = ad; b_wdata = d;
  endtask

  task automatic check(input string tag, input logic [15:0] act, exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic b_read(input logic [AW-1:0] ad);
    pb(0, 1, 1, ad, 0); tick(); idle();
  endtask

  initial begin
    repeat (3) tick();
    check("R1 a_irq_n", a_irq_n, 1);
    check("R1 b_irq_n", b_irq_n, 1);
    check("R1 a_rdata", a_rdata, 0);
    check("R1 b_rdata", b_rdata, 0);
    rst_n = 1; tick();
    check("R1 a_irq_n after release", a_irq_n, 1);

    for (int i = 0; i < NV; i++) begin
      pa(0, 1, 0, VEC[i][AW+15:16], VEC[i][15:0]); tick(); idle();
      b_read(VEC[i][AW+15:16]);
      check("R2 cross-port readback", b_rdata, VEC[i][15:0]);
    end

    // R3: deselected write ignored, rdata held
    pa(0, 1, 1, 10'd0, 0); tick(); keep = a_rdata;
    pa(1, 0, 0, 10'd0, 16'hDEAD); tick();
    check("R3 a_rdata held", a_rdata, keep);
    idle(); b_read(10'd0);
    check("R3 no write when deselected", b_rdata, 16'hA5A5);

    // R4
    pb(0, 1, 0, MBX_A, 16'h1234); tick(); idle();
    check("R4 a_irq_n set", a_irq_n, 0);
    check("R4 b_irq_n untouched", b_irq_n, 1);

    // R5: read with oe high keeps it set
    pa(0, 1, 1, MBX_A, 0); tick(); idle();
    check("R5 oe off keeps irq", a_irq_n, 0);
    check("R9 mailbox A read by A", a_rdata, 16'h1234);
    // R5: write with oe low clears
    pa(0, 0, 0, MBX_A, 16'h5678); tick(); idle();
    check("R5 clear by write with oe", a_irq_n, 1);
    b_read(MBX_A);
    check("R9 mailbox A read by B", b_rdata, 16'h5678);

    // R6
    pa(0, 1, 0, MBX_B, 16'hCAFE); tick(); idle();
    check("R6 b_irq_n set", b_irq_n, 0);
    // R7
    pb(0, 0, 0, MBX_B, 16'hBEEF); tick(); idle();
    check("R7 write does not clear", b_irq_n, 0);
    pb(0, 1, 1, MBX_B, 0); tick(); idle();
    check("R7 read with oe off does not clear", b_irq_n, 0);
    pb(0, 0, 1, MBX_B, 0); tick(); idle();
    check("R7 proper read clears", b_irq_n, 1);
    check("R9 mailbox B holds B write", b_rdata, 16'hBEEF);

    // R8: set and clear together on both doorbells
    pb(0, 0, 0, MBX_A, 16'h0F0F); pa(0, 0, 1, MBX_A, 0); tick(); idle();
    check("R8 a set wins", a_irq_n, 0);
    pa(0, 1, 0, MBX_B, 16'hF0F0); pb(0, 0, 1, MBX_B, 0); tick(); idle();
    check("R8 b set wins", b_irq_n, 0);

    // R10
    pa(0, 1, 0, 10'd5, 16'h1111); pb(0, 1, 0, 10'd5, 16'h2222); tick(); idle();
    b_read(10'd5);
    check("R10 port A wins collision", b_rdata, 16'h1111);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule